// File: doc/BRIEF.md
# Dual-Channel Threshold Alarm Monitor

This block watches four streams of digitized readings: a temperature and a current reading for each of two channels. Each stream feeds its own comparator. A comparator is either a latching over-limit detector with separate set and release levels, or an out-of-range detector with a selectable release margin. Each comparator is switched on or off on its own. When switched off, its readings have no effect on any output.

Each channel drives one active-high safe output from its own two comparators. Both channels drive one shared alarm output. A single configuration bit decides what the alarm shows. It shows either the latched fault state or the out-of-limit result of the most recent reading. That bit never reaches the safe outputs.

The block sits between an analog front end that delivers samples with strobes and the bias control logic that reacts to the safe outputs. Thresholds and mode bits come from register storage outside this block.

Top module: `tam_monitor`

## Requirements
- R1: While `rst_ni` is low, and after it returns high, every fault and every last-sample state is clear, and `safe_o` and `alarm_o` are low.
- R2: Comparator index 2c watches channel c temperature and index 2c+1 watches channel c current. `safe_o[c]` depends only on comparators 2c and 2c+1.
- R3: A comparator whose `cmp_en_i` bit is 0 has its state cleared at the next clock. Its samples do not change any output.
- R4: With `cmp_win_i[k]`=0 (hysteresis mode), a valid sample above `thr_hi_i[k]` sets fault k.
- R5: In hysteresis mode, a valid sample below `thr_lo_i[k]` clears fault k. A sample between the thresholds leaves it unchanged.
- R6: With `cmp_win_i[k]`=1 (window mode), a valid sample above `thr_hi_i[k]` or below `thr_lo_i[k]` sets fault k.
- R7: In window mode, a set fault clears on a valid sample s with s >= lo+h and s+h <= hi. Otherwise it holds. h is 0, 2, 4 or 8 for `hyst_sel_i` = 00, 01, 10, 11.
- R8: Comparator k changes state only in a cycle where `meas_vld_i[k]` is high.
- R9: `safe_o[c]` is the OR of the enabled faults of channel c. It is visible on the clock after the valid sample.
- R10: With `alarm_cmp_i`=0, `alarm_o` is the OR of all enabled faults.
- R11: With `alarm_cmp_i`=1, `alarm_o` is the OR over enabled comparators of the most recent valid sample being out of limit: above hi in hysteresis mode, outside [lo, hi] in window mode. `safe_o` is unaffected by this bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| meas_i | input | 2*NUM_CH x DATA_W | Sample per comparator |
| meas_vld_i | input | 2*NUM_CH | Sample strobe per comparator |
| thr_hi_i | input | 2*NUM_CH x DATA_W | Upper threshold per comparator |
| thr_lo_i | input | 2*NUM_CH x DATA_W | Lower threshold per comparator |
| cmp_en_i | input | 2*NUM_CH | Comparator enable |
| cmp_win_i | input | 2*NUM_CH | Mode: 0 hysteresis, 1 window |
| hyst_sel_i | input | 2 | Window release margin code |
| alarm_cmp_i | input | 1 | Alarm source: 0 latched faults, 1 last-sample result |
| safe_o | output | NUM_CH | Per-channel safe output, bit c for channel c |
| alarm_o | output | 1 | Shared alarm |

## Verification
The assertions assume three things about the inputs. Thresholds are ordered with lo below hi. Enables and modes are steady across the clock edge that takes a sample. A strobe is held for exactly the cycle its sample is taken. The stimulus changes configuration and samples only on the falling edge. It keeps every lower threshold at least 16 below its upper threshold, so the window release point is reachable for every margin code. Sweeps run every sample value up and back down for each comparator, mode, margin code and alarm source. A pseudo-random pass then mixes all four comparators.

// File: rtl/tam_pkg.sv
package tam_pkg;
  localparam int HYST_W = 4;
  localparam int CH_CMPS = 2;  // temperature, current

  typedef enum logic {
    MODE_HYST = 1'b0,
    MODE_WIN  = 1'b1
  } cmp_mode_e;

  // release margin: 0,2,4,8 LSB
  function automatic logic [HYST_W-1:0] hyst_amount(input logic [1:0] sel);
    logic [HYST_W-1:0] amt;
    if (sel == 2'b00) amt = '0;
    else              amt = HYST_W'(1) << sel;
    return amt;
  endfunction
endpackage

// File: rtl/tam_cmp.sv
module tam_cmp #(
  parameter int DATA_W = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      win_i,
  input  logic [tam_pkg::HYST_W-1:0] hyst_i,
  input  logic [DATA_W-1:0]         smp_i,
  input  logic                      vld_i,
  input  logic [DATA_W-1:0]         hi_i,
  input  logic [DATA_W-1:0]         lo_i,
  output logic                      fault_o,
  output logic                      raw_o
);
  import tam_pkg::*;
  localparam int EXT_W = DATA_W + 1;

  logic             above, below, outside;
  logic [EXT_W-1:0] lo_rel, smp_rel;
  logic             release_ok;
  logic             fault_d, raw_d;
  cmp_mode_e        mode;

  assign mode    = cmp_mode_e'(win_i);
  assign above   = smp_i > hi_i;
  assign below   = smp_i < lo_i;
  assign outside = above | below;

  assign lo_rel     = EXT_W'(lo_i) + EXT_W'(hyst_i);
  assign smp_rel    = EXT_W'(smp_i) + EXT_W'(hyst_i);
  assign release_ok = (EXT_W'(smp_i) >= lo_rel) && (smp_rel <= EXT_W'(hi_i));

  always_comb begin
    fault_d = fault_o;
    raw_d   = raw_o;
    unique case (mode)
      MODE_HYST: begin
        raw_d = above;
        if (above)      fault_d = 1'b1;
        else if (below) fault_d = 1'b0;
      end
      MODE_WIN: begin
        raw_d = outside;
        if (outside)         fault_d = 1'b1;
        else if (release_ok) fault_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      raw_o   <= 1'b0;
    end else if (!en_i) begin
      fault_o <= 1'b0;
      raw_o   <= 1'b0;
    end else if (vld_i) begin
      fault_o <= fault_d;
      raw_o   <= raw_d;
    end
  end
endmodule

// File: rtl/tam_combine.sv
module tam_combine #(
  parameter int NUM_CH = 2,
  localparam int NCMP = tam_pkg::CH_CMPS * NUM_CH
) (
  input  logic [NCMP-1:0]   fault_i,
  input  logic [NCMP-1:0]   raw_i,
  input  logic [NCMP-1:0]   en_i,
  input  logic              alarm_cmp_i,
  output logic [NUM_CH-1:0] safe_o,
  output logic              alarm_o
);
  import tam_pkg::*;
  logic [NCMP-1:0] live_fault, alarm_src;

  assign live_fault = fault_i & en_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign safe_o[c] = |live_fault[c*CH_CMPS +: CH_CMPS];
  end

  assign alarm_src = alarm_cmp_i ? (raw_i & en_i) : live_fault;
  assign alarm_o   = |alarm_src;
endmodule

// File: rtl/tam_monitor.sv
module tam_monitor #(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 2,
  localparam int NCMP = tam_pkg::CH_CMPS * NUM_CH
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NCMP-1:0][DATA_W-1:0]  meas_i,
  input  logic [NCMP-1:0]              meas_vld_i,
  input  logic [NCMP-1:0][DATA_W-1:0]  thr_hi_i,
  input  logic [NCMP-1:0][DATA_W-1:0]  thr_lo_i,
  input  logic [NCMP-1:0]              cmp_en_i,
  input  logic [NCMP-1:0]              cmp_win_i,
  input  logic [1:0]                   hyst_sel_i,
  input  logic                         alarm_cmp_i,
  output logic [NUM_CH-1:0]            safe_o,
  output logic                         alarm_o
);
  import tam_pkg::*;

  logic [HYST_W-1:0] hyst_amt;
  logic [NCMP-1:0]   fault, raw;

  assign hyst_amt = hyst_amount(hyst_sel_i);

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    tam_cmp #(.DATA_W(DATA_W)) u_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (cmp_en_i[k]),
      .win_i  (cmp_win_i[k]),
      .hyst_i (hyst_amt),
      .smp_i  (meas_i[k]),
      .vld_i  (meas_vld_i[k]),
      .hi_i   (thr_hi_i[k]),
      .lo_i   (thr_lo_i[k]),
      .fault_o(fault[k]),
      .raw_o  (raw[k])
    );
  end

  tam_combine #(.NUM_CH(NUM_CH)) u_combine (
    .fault_i    (fault),
    .raw_i      (raw),
    .en_i       (cmp_en_i),
    .alarm_cmp_i(alarm_cmp_i),
    .safe_o     (safe_o),
    .alarm_o    (alarm_o)
  );
endmodule

// File: rtl/tam_monitor_chk.sv
module tam_monitor_chk #(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 2,
  localparam int NCMP = 2 * NUM_CH
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NCMP-1:0][DATA_W-1:0]  meas_i,
  input logic [NCMP-1:0]              meas_vld_i,
  input logic [NCMP-1:0][DATA_W-1:0]  thr_hi_i,
  input logic [NCMP-1:0][DATA_W-1:0]  thr_lo_i,
  input logic [NCMP-1:0]              cmp_en_i,
  input logic [NCMP-1:0]              cmp_win_i,
  input logic                         alarm_cmp_i,
  input logic [NUM_CH-1:0]            safe_o,
  input logic                         alarm_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> (safe_o == '0) && !alarm_o); // R1

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_SAFE_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_en_i[2*c +: 2] == 2'b00) |-> !safe_o[c]); // R3

    AST_SAFE_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && ($past(meas_vld_i[2*c +: 2]) == 2'b00) && $stable(cmp_en_i[2*c +: 2]))
      |-> $stable(safe_o[c])); // R8

    AST_HYST_SETS_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (meas_vld_i[2*c] && cmp_en_i[2*c] && !cmp_win_i[2*c] && (meas_i[2*c] > thr_hi_i[2*c]))
      |=> (safe_o[c] || !cmp_en_i[2*c])); // R4

    AST_WIN_LOW_SETS_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (meas_vld_i[2*c+1] && cmp_en_i[2*c+1] && cmp_win_i[2*c+1] && (meas_i[2*c+1] < thr_lo_i[2*c+1]))
      |=> (safe_o[c] || !cmp_en_i[2*c+1])); // R6

    AST_ALARM_COVERS_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!alarm_cmp_i && safe_o[c]) |-> alarm_o); // R10
  end
endmodule

bind tam_monitor tam_monitor_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .meas_i     (meas_i),
  .meas_vld_i (meas_vld_i),
  .thr_hi_i   (thr_hi_i),
  .thr_lo_i   (thr_lo_i),
  .cmp_en_i   (cmp_en_i),
  .cmp_win_i  (cmp_win_i),
  .alarm_cmp_i(alarm_cmp_i),
  .safe_o     (safe_o),
  .alarm_o    (alarm_o)
);

// File: tb/tam_monitor_tb.sv
module tam_monitor_tb_top;
  localparam int W = 6;
  localparam int NC = 2;
  localparam int NK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NK-1:0][W-1:0] meas = '0;
  logic [NK-1:0] vld = '0;
  logic [NK-1:0][W-1:0] hi = '0;
  logic [NK-1:0][W-1:0] lo = '0;
  logic [NK-1:0] en = '0;
  logic [NK-1:0] win = '0;
  logic [1:0] hsel = '0;
  logic acmp = 1'b0;
  logic [NC-1:0] safe;
  logic alarm;

  int n_chk = 0;
  int n_fail = 0;
  bit m_flag [NK];
  bit m_raw [NK];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  tam_monitor #(.DATA_W(W), .NUM_CH(NC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .meas_i(meas), .meas_vld_i(vld),
    .thr_hi_i(hi), .thr_lo_i(lo), .cmp_en_i(en), .cmp_win_i(win),
    .hyst_sel_i(hsel), .alarm_cmp_i(acmp), .safe_o(safe), .alarm_o(alarm)
  );

  function automatic int h_of(input logic [1:0] s);
    return (s == 2'b00) ? 0 : (1 << s);
  endfunction

  task automatic model_clear_disabled();
    for (int k = 0; k < NK; k++) if (!en[k]) begin m_flag[k] = 0; m_raw[k] = 0; end
  endtask

  task automatic model_sample(input int k, input int v);
    int h;
    bit up, dn;
    h  = h_of(hsel);
    up = v > int'(hi[k]);
    dn = v < int'(lo[k]);
    if (!en[k]) return;
    if (!win[k]) begin
      m_raw[k] = up;
      if (up) m_flag[k] = 1; else if (dn) m_flag[k] = 0;
    end else begin
      m_raw[k] = up | dn;
      if (up | dn) m_flag[k] = 1;
      else if (v >= int'(lo[k]) + h && v + h <= int'(hi[k])) m_flag[k] = 0;
    end
  endtask

  task automatic compare(input string tag);
    logic [NC-1:0] es;
    logic ea;
    es = '0; ea = 1'b0;
    for (int c = 0; c < NC; c++)
      es[c] = (m_flag[2*c] & en[2*c]) | (m_flag[2*c+1] & en[2*c+1]);
    for (int k = 0; k < NK; k++) ea |= en[k] & (acmp ? m_raw[k] : m_flag[k]);
    n_chk++;
    if (safe !== es) begin
      n_fail++;
      $display("FAIL %s R9 safe: actual %b expected %b", tag, safe, es);
    end
    n_chk++;
    if (alarm !== ea) begin
      n_fail++;
      $display("FAIL %s %s alarm: actual %b expected %b", tag, acmp ? "R11" : "R10", alarm, ea);
    end
  endtask

  task automatic step(input int k, input int v, input string tag);
    @(negedge clk);
    meas[k] = W'(v);
    vld[k] = 1'b1;
    model_sample(k, v);
    @(negedge clk);
    vld = '0;
    compare(tag);
  endtask

  task automatic set_en(input logic [NK-1:0] e);
    @(negedge clk);
    en = e;
    model_clear_disabled();
    @(negedge clk);
  endtask

  task automatic lfsr_next();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int k = 0; k < NK; k++) begin hi[k] = 6'd40; lo[k] = 6'd20; end
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // sweeps: each comparator alone, both modes, all margins, both alarm sources
    for (int k = 0; k < NK; k++)
      for (int w = 0; w < 2; w++)
        for (int hs = 0; hs < 4; hs++)
          for (int ac = 0; ac < 2; ac++) begin
            set_en('0);
            win = {NK{w[0]}};
            hsel = hs[1:0];
            acmp = ac[0];
            set_en(NK'(1) << k);
            for (int v = 0; v < 64; v++) step(k, v, w ? "R6/R7 R2 up" : "R4/R5 R2 up");
            for (int v = 63; v >= 0; v--) step(k, v, w ? "R6/R7 R2 down" : "R4/R5 R2 down");
          end

    // R8: samples without strobe are ignored
    set_en('0);
    win = '0; acmp = 1'b0;
    set_en(4'b0001);
    step(0, 50, "R8 set");
    @(negedge clk); meas[0] = 6'd0;
    repeat (3) @(negedge clk);
    compare("R8 no strobe low");
    step(0, 5, "R8 cleared");
    @(negedge clk); meas[0] = 6'd63;
    repeat (3) @(negedge clk);
    compare("R8 no strobe high");

    // R3: disabled comparator ignored; disabling clears state
    set_en(4'b1110);
    step(0, 63, "R3 disabled sample");
    set_en(4'b1111);
    step(1, 63, "R3 set current");
    set_en(4'b1101);
    compare("R3 cleared on disable");
    set_en(4'b1111);
    compare("R3 stays clear on enable");

    // mixed pass: all comparators, distinct thresholds and modes
    set_en('0);
    for (int k = 0; k < NK; k++) begin hi[k] = W'(36 + 4 * k); lo[k] = W'(12 + 2 * k); end
    win = 4'b0110;
    set_en(4'b1111);
    for (int i = 0; i < 3000; i++) begin
      lfsr_next();
      if (i % 500 == 0) begin acmp = ~acmp; hsel = lfsr[9:8]; end
      step(int'(lfsr[1:0]), int'(lfsr[7:2]), "R2 R9 mixed");
    end

    // R1: reset mid-run
    step(0, 63, "R1 pre");
    @(negedge clk); rst_n = 1'b0;
    for (int k = 0; k < NK; k++) begin m_flag[k] = 0; m_raw[k] = 0; end
    @(negedge clk);
    compare("R1 mid reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after mid reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule